// File: doc/BRIEF.md
# Reservation Monitor for Linked Loads and Conditional Stores

This block serves several requesters that share one small on-chip memory. It also tracks the reservations that linked loads and conditional stores need. A requester can issue four kinds of access: a plain load, a plain store, a linked load and a conditional store. A linked load returns the stored word and remembers, for that requester only, which address it read. A conditional store writes only if that reservation is still valid. It reports one bit of success, so software can retry a read-modify-write sequence until the bit comes back as one.

A reservation is lost in three ways. The same requester issues a new linked load, the same requester issues any conditional store, or a different requester completes a store to the reserved address. A conditional store that fails leaves the memory untouched. Requests that arrive in the same cycle go through a fixed-priority arbiter, and only one access completes per cycle.

Top module: `llsc_monitor`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rdData` is 0, `scOk` is 0, every memory word reads as 0 and no requester holds a reservation. A conditional store issued straight after reset therefore fails.
- R2: Each requester's 2-bit operation field, at bits [2i+1:2i] of `reqOp`, is encoded as 00 plain load, 01 plain store, 10 linked load and 11 conditional store. `ready[i]` is high, combinationally, in the cycle its request is accepted. `rdData` and `scOk` show that access's results in the following cycle.
- R3: Among the requesters with `reqValid` high, the one with the lowest index is accepted. `ready` is one-hot or zero, and it is zero when no request is valid.
- R4: A plain or linked load returns the memory word at its address in `rdData`.
- R5: A linked load records its address as that requester's only reservation, replacing any earlier one.
- R6: A conditional store whose requester holds a valid reservation for that same address writes the data and returns `scOk` = 1.
- R7: A conditional store without such a reservation does not write memory and returns `scOk` = 0. `scOk` is 1 only after a successful conditional store.
- R8: Any completed store, plain or conditional, clears the reservation of every other requester that holds the written address. Reservations for other addresses remain.
- R9: A conditional store always clears its issuer's own reservation, whether it succeeds or fails, so a second one to the same address fails.
- R10: A plain store always writes memory and returns `scOk` = 0.
- R11: `rdData` keeps its previous value after a store of either kind and after an idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | NUM_REQ | Request valid, one bit per requester |
| reqOp | input | 2*NUM_REQ | Operation code per requester |
| reqAddr | input | ADDR_W*NUM_REQ | Word address per requester |
| reqWdata | input | DATA_W*NUM_REQ | Store data per requester |
| ready | output | NUM_REQ | Acceptance, one-hot, this cycle |
| rdData | output | DATA_W | Load result, valid the cycle after acceptance |
| scOk | output | 1 | Conditional-store success, valid the cycle after acceptance |

## Verification
The assertions check the arbiter on every cycle: ready is one-hot, only valid requesters are accepted, and no lower-index requester is ever passed over. They also check on every cycle that a success bit only follows an accepted conditional store, and that the read register holds across idle cycles and stores. Whether a conditional store should succeed depends on the history of linked loads and stores from other requesters. Only the bench's scenarios show this. They sweep every pair of requesters through linked load, intervening store and conditional store, including stores to neighbouring addresses and the case where a requester stores to its own reservation. The bench reads memory back after each sequence to confirm that failed stores left it unchanged.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_LINK  = 2'b10,
    OP_COND  = 2'b11
  } memOp_t;

  typedef struct packed {
    logic accept;
    logic memWrite;
    logic captureRead;
    logic condPass;
  } ctrlStrobe_t;

endpackage

// File: rtl/llsc_ctrl.sv
module llsc_ctrl
  import llsc_pkg::*;
#(
  parameter int NUM_REQ = 3,
  parameter int ADDR_W  = 4,
  localparam int IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_REQ-1:0]          reqValid,
  input  logic [2*NUM_REQ-1:0]        reqOp,
  input  logic [ADDR_W*NUM_REQ-1:0]   reqAddr,
  output logic [NUM_REQ-1:0]          grant,
  output logic [IDX_W-1:0]            selIdx,
  output ctrlStrobe_t                 strobe
);

  logic                found;
  memOp_t              selOp;
  logic [ADDR_W-1:0]   selAddr;
  logic                ownHit;
  logic [NUM_REQ-1:0]  resValid;
  logic [ADDR_W-1:0]   resAddr [NUM_REQ];

  // Fixed priority: the lowest index wins
  always_comb begin
    grant  = '0;
    selIdx = '0;
    found  = 1'b0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (reqValid[i] && !found) begin
        grant[i] = 1'b1;
        selIdx   = IDX_W'(i);
        found    = 1'b1;
      end
    end
  end

  assign selOp   = memOp_t'(reqOp[int'(selIdx)*2 +: 2]);
  assign selAddr = reqAddr[int'(selIdx)*ADDR_W +: ADDR_W];
  assign ownHit  = resValid[selIdx] && (resAddr[selIdx] == selAddr);

  always_comb begin
    strobe.accept      = found;
    strobe.condPass    = found && (selOp == OP_COND) && ownHit;
    strobe.memWrite    = found && ((selOp == OP_STORE) || ((selOp == OP_COND) && ownHit));
    strobe.captureRead = found && ((selOp == OP_LOAD) || (selOp == OP_LINK));
  end

  // One reservation entry per requester
  for (genvar g = 0; g < NUM_REQ; g++) begin : gResv
    always_ff @(posedge clk) begin
      if (!rstN) begin
        resValid[g] <= 1'b0;
        resAddr[g]  <= '0;
      end else if (grant[g] && (selOp == OP_LINK)) begin
        resValid[g] <= 1'b1;
        resAddr[g]  <= selAddr;
      end else if (grant[g] && (selOp == OP_COND)) begin
        resValid[g] <= 1'b0;
      end else if (!grant[g] && strobe.memWrite && (resAddr[g] == selAddr)) begin
        resValid[g] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/llsc_datapath.sv
module llsc_datapath
  import llsc_pkg::*;
#(
  parameter int NUM_REQ = 3,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 16,
  localparam int IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrlStrobe_t                 strobe,
  input  logic [IDX_W-1:0]            selIdx,
  input  logic [ADDR_W*NUM_REQ-1:0]   reqAddr,
  input  logic [DATA_W*NUM_REQ-1:0]   reqWdata,
  output logic [DATA_W-1:0]           rdData,
  output logic                        scOk
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] selAddr;
  logic [DATA_W-1:0] selWdata;

  assign selAddr  = reqAddr[int'(selIdx)*ADDR_W +: ADDR_W];
  assign selWdata = reqWdata[int'(selIdx)*DATA_W +: DATA_W];

  for (genvar w = 0; w < DEPTH; w++) begin : gWord
    always_ff @(posedge clk) begin
      if (!rstN) begin
        mem[w] <= '0;
      end else if (strobe.memWrite && (selAddr == ADDR_W'(w))) begin
        mem[w] <= selWdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
      scOk   <= 1'b0;
    end else begin
      scOk <= strobe.condPass;
      if (strobe.captureRead) begin
        rdData <= mem[selAddr];
      end
    end
  end

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int NUM_REQ = 3,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_REQ-1:0]          reqValid,
  input  logic [2*NUM_REQ-1:0]        reqOp,
  input  logic [ADDR_W*NUM_REQ-1:0]   reqAddr,
  input  logic [DATA_W*NUM_REQ-1:0]   reqWdata,
  output logic [NUM_REQ-1:0]          ready,
  output logic [DATA_W-1:0]           rdData,
  output logic                        scOk
);

  localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;

  ctrlStrobe_t      strobe;
  logic [IDX_W-1:0] selIdx;

  llsc_ctrl #(.NUM_REQ(NUM_REQ), .ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqOp    (reqOp),
    .reqAddr  (reqAddr),
    .grant    (ready),
    .selIdx   (selIdx),
    .strobe   (strobe)
  );

  llsc_datapath #(.NUM_REQ(NUM_REQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .selIdx   (selIdx),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .rdData   (rdData),
    .scOk     (scOk)
  );

endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int NUM_REQ = 3,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 16
) (
  input logic                        clk,
  input logic                        rstN,
  input logic [NUM_REQ-1:0]          reqValid,
  input logic [2*NUM_REQ-1:0]        reqOp,
  input logic [NUM_REQ-1:0]          ready,
  input logic [DATA_W-1:0]           rdData,
  input logic                        scOk
);

  logic [1:0] gOp;
  always_comb begin
    gOp = 2'b00;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (ready[i]) gOp = reqOp[i*2 +: 2];
    end
  end

  logic gStore;
  assign gStore = (ready != '0) && gOp[0];

  // R3: at most one acceptance per cycle
  a_r3_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ready));

  // R3: only valid requesters are accepted, and any valid request yields an acceptance
  a_r3_grant_valid: assert property (@(posedge clk) disable iff (!rstN)
    ((ready & ~reqValid) == '0) && ((reqValid != '0) == (ready != '0)));

  // R3: no lower-index valid requester is passed over
  a_r3_priority: assert property (@(posedge clk) disable iff (!rstN)
    (ready != '0) |-> ((reqValid & (ready - NUM_REQ'(1))) == '0));

  // R7: success only follows an accepted conditional store
  a_r7_sc_source: assert property (@(posedge clk) disable iff (!rstN)
    scOk |-> $past((ready != '0) && (gOp == 2'b11)));

  // R11: read result holds across idle cycles and stores
  a_r11_hold: assert property (@(posedge clk) disable iff (!rstN)
    ((ready == '0) || gStore) |=> $stable(rdData));

endmodule

bind llsc_monitor llsc_monitor_chk #(.NUM_REQ(NUM_REQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqOp    (reqOp),
  .ready    (ready),
  .rdData   (rdData),
  .scOk     (scOk)
);

// File: tb/llsc_monitor_tb.sv
module llsc_monitor_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NREQ = 3;
  localparam int AW   = 4;
  localparam int DW   = 16;
  localparam int WORDS = 1 << AW;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic [NREQ-1:0]      reqValid = '0;
  logic [2*NREQ-1:0]    reqOp = '0;
  logic [AW*NREQ-1:0]   reqAddr = '0;
  logic [DW*NREQ-1:0]   reqWdata = '0;
  logic [NREQ-1:0]      ready;
  logic [DW-1:0]        rdData;
  logic                 scOk;

  int nChecks = 0;
  int nErr = 0;

  logic [DW-1:0] mMem [WORDS];
  logic          mResV [NREQ];
  int            mResA [NREQ];
  logic [DW-1:0] expRd;

  always #(CLK_PERIOD/2) clk = ~clk;

  llsc_monitor #(.NUM_REQ(NREQ), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqWdata(reqWdata),
    .ready(ready), .rdData(rdData), .scOk(scOk)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Single access from requester r; the reference model is updated from the requirements
  task automatic runOp(input int r, input logic [1:0] op, input int a, input logic [DW-1:0] d, input string tag);
    bit hit, expSc, wr;
    hit   = mResV[r] && (mResA[r] == a);
    expSc = (op == 2'b11) && hit;
    wr    = (op == 2'b01) || expSc;
    if (op == 2'b00 || op == 2'b10) expRd = mMem[a];
    if (op == 2'b10) begin mResV[r] = 1'b1; mResA[r] = a; end
    if (op == 2'b11) mResV[r] = 1'b0;
    if (wr) begin
      mMem[a] = d;
      for (int j = 0; j < NREQ; j++)
        if (j != r && mResV[j] && mResA[j] == a) mResV[j] = 1'b0;
    end
    @(negedge clk);
    reqValid = NREQ'(1) << r;
    reqOp[r*2 +: 2] = op;
    reqAddr[r*AW +: AW] = AW'(a);
    reqWdata[r*DW +: DW] = d;
    #1;
    check(ready == (NREQ'(1) << r), {"R3 R2 ready ", tag}, 32'(ready), 32'(NREQ'(1) << r));
    @(negedge clk);
    reqValid = '0;
    check(scOk == expSc, {"scOk ", tag}, 32'(scOk), 32'(expSc));
    check(rdData == expRd, {"rdData ", tag}, 32'(rdData), 32'(expRd));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nErr++;
    nChecks++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    for (int i = 0; i < WORDS; i++) mMem[i] = '0;
    for (int i = 0; i < NREQ; i++) begin mResV[i] = 1'b0; mResA[i] = 0; end
    expRd = '0;

    repeat (3) @(negedge clk);
    check(rdData == '0, "R1 rdData in reset", 32'(rdData), 0);
    check(scOk == 1'b0, "R1 scOk in reset", 32'(scOk), 0);
    rstN = 1'b1;
    #1;
    check(ready == '0, "R3 idle ready", 32'(ready), 0);

    // R1: no reservation after reset, memory zero
    runOp(1, 2'b11, 3, 16'h1111, "R1 cond store after reset");
    runOp(1, 2'b00, 3, 16'h0, "R1 R7 memory untouched");

    // R10 R11: plain stores preload words
    runOp(0, 2'b01, 8, 16'hA008, "R10 store");
    runOp(1, 2'b01, 9, 16'hA009, "R10 R11 store");
    runOp(2, 2'b01, 10, 16'hA00A, "R10 store");
    runOp(2, 2'b00, 9, 16'h0, "R4 load");

    // R3: every pattern of simultaneous requests
    for (int p = 1; p < (1 << NREQ); p++) begin
      int win;
      win = 0;
      while (!p[win]) win++;
      @(negedge clk);
      for (int i = 0; i < NREQ; i++) begin
        reqOp[i*2 +: 2] = 2'b00;
        reqAddr[i*AW +: AW] = AW'(8 + i);
      end
      reqValid = NREQ'(p);
      #1;
      check(ready == (NREQ'(1) << win), "R3 priority", 32'(ready), 32'(NREQ'(1) << win));
      @(negedge clk);
      reqValid = '0;
      expRd = mMem[8 + win];
      check(rdData == expRd, "R3 R4 winner data", 32'(rdData), 32'(expRd));
    end
    #1;
    check(ready == '0, "R3 no request", 32'(ready), 0);
    @(negedge clk);
    check(rdData == expRd, "R11 idle hold", 32'(rdData), 32'(expRd));

    // R5: a new linked load replaces the old reservation
    runOp(0, 2'b10, 5, 16'h0, "R5 link");
    runOp(0, 2'b10, 6, 16'h0, "R5 relink");
    runOp(0, 2'b11, 5, 16'h5555, "R5 R7 old address fails");
    runOp(0, 2'b10, 5, 16'h0, "R5 link");
    runOp(0, 2'b10, 6, 16'h0, "R5 relink");
    runOp(0, 2'b11, 6, 16'h6666, "R5 R6 new address passes");
    // R9: second conditional store fails
    runOp(1, 2'b10, 7, 16'h0, "R9 link");
    runOp(1, 2'b11, 7, 16'h7777, "R9 R6 first");
    runOp(1, 2'b11, 7, 16'h7778, "R9 second fails");
    runOp(1, 2'b00, 7, 16'h0, "R9 R7 memory kept");

    // R6 R7 R8: sweep requester pairs and intervening activity
    for (int a = 0; a < NREQ; a++) begin
      for (int b = 0; b < NREQ; b++) begin
        for (int m = 0; m < 4; m++) begin
          int ad;
          ad = (a * 5 + b * 3 + m) % 12;
          runOp(a, 2'b10, ad, 16'h0, "R5 sweep link");
          if (m == 1) runOp(b, 2'b01, ad, DW'(16'h1000 + ad), "R8 store same");
          if (m == 2) runOp(b, 2'b01, (ad + 1) % WORDS, DW'(16'h2000 + ad), "R8 store other");
          if (m == 3) begin
            runOp(b, 2'b10, ad, 16'h0, "R8 other link");
            runOp(b, 2'b11, ad, DW'(16'h3000 + ad), "R8 R6 other cond");
          end
          runOp(a, 2'b11, ad, DW'(16'h4000 + a * 256 + b * 16 + m), "R6 R7 R8 sweep cond");
          runOp(a, 2'b00, ad, 16'h0, "R4 R7 readback");
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule